// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Entry Load Path

This block holds a four-way, 32-set translation buffer and the register-driven write path that fills it. Software writes three registers: a page-entry high register with the virtual page number and address-space ID, a page-entry low register with the physical page number and attribute bits, and a control register with the index mode, the replace-way field and a flush bit. A one-cycle load strobe writes one entry. The set is taken from the high register, and the way comes from the replace-way field.

When a translation miss is signalled, hardware places the faulting virtual page number into the high register and keeps the address-space ID there. The miss handler then only has to write the low register before it pulses the load strobe. Software can also target any entry directly by rewriting the high register and the replace-way field. A direct read port returns any stored entry by set and way. A compare port looks up a virtual page number and address-space ID and reports a hit, the matching way and the physical page number.

Top module: `tlb_loader`

## Requirements
- R1: After reset the high, low and control registers read 0, no entry is valid, and the compare port reports no hit.
- R2: Register select codes are 0 for high, 1 for low and 2 for control. Register reads give the following fields, with every other bit reading 0. High: VPN at bits 31..10 and ASID at bits 7..0. Low: PPN at bits 28..10, V at 8, PR at 6..5, SZ at 4, C at 3, D at 2 and SH at 1. Control: SV at 8, RC at 5..4, IX at 1 and AT at 0. The flush bit at 2 always reads 0.
- R3: With IX=0 a load writes the set given by virtual address bits 16..12 of the high register.
- R4: With IX=1 a load writes the set given by address bits 16..12 XOR ASID bits 4..0.
- R5: A load writes only the way named by RC and leaves the other ways of that set unchanged.
- R6: A loaded entry holds VPN bits 31..17 and 11..10, the ASID, V from the low register, the PPN, PR, SZ, C, D and SH. It can be read on the read port in the cycle after the strobe.
- R7: A miss pulse writes its VPN (address bits 31..10) into the high register and leaves the ASID unchanged. If the miss coincides with a software write of the high register, the VPN comes from the miss and the ASID comes from the software write.
- R8: A load uses the register values held before the strobe's clock edge, so a register write in the same cycle affects only later loads.
- R9: Writing the control register with bit 2 set clears every valid bit. A load in the same cycle is written after the clear and remains valid.
- R10: The compare port indexes a set from its inputs using the current IX. It hits when a valid entry matches VPN bits 31..17, VPN bits 11..10 and the ASID, and it reports the lowest such way and its PPN.
- R11: In cycles without a load or a flush, no stored entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_sel | input | 2 | Register select for writes (0 high, 1 low, 2 control) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 32 | Register read data |
| miss_valid | input | 1 | Translation miss pulse |
| miss_vpn | input | 22 | Faulting VPN, address bits 31..10 |
| load_strobe | input | 1 | Load-entry command |
| rd_set | input | 5 | Read port set |
| rd_way | input | 2 | Read port way |
| rd_valid | output | 1 | Stored valid bit |
| rd_vpn_hi | output | 15 | Stored VPN bits 31..17 |
| rd_vpn_lo | output | 2 | Stored VPN bits 11..10 |
| rd_asid | output | 8 | Stored ASID |
| rd_ppn | output | 19 | Stored PPN bits 28..10 |
| rd_pr | output | 2 | Stored protection field |
| rd_sz | output | 1 | Stored size bit |
| rd_c | output | 1 | Stored cacheable bit |
| rd_d | output | 1 | Stored dirty bit |
| rd_sh | output | 1 | Stored shared bit |
| cmp_vpn | input | 22 | Lookup VPN, address bits 31..10 |
| cmp_asid | input | 8 | Lookup ASID |
| cmp_hit | output | 1 | Lookup hit |
| cmp_way | output | 2 | Lowest matching way |
| cmp_ppn | output | 19 | PPN of the matching entry |

## Verification
Two pairs of functions can fall in the same clock edge. The first pair is a hardware miss and a software write of the high register. The bench raises both in one cycle with different VPNs and a new ASID, then reads the register back to confirm that the VPN comes from the miss and the ASID from the software write. The second pair is a load strobe together with a register write. The bench pairs the strobe first with a low-register write and then with a flush-carrying control write. It judges the outcome by reading entries on the read port: the stored PPN must be the older value, the way must follow the older RC, and the freshly loaded entry must be the only valid one after the flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int WAYS    = 4;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = 5;
    localparam int SETS    = 1 << SET_W;
    localparam int VPN_W   = 22;
    localparam int ASID_W  = 8;
    localparam int PPN_W   = 19;
    localparam int VHI_W   = 15;
    localparam int VLO_W   = 2;
    localparam int IDX_LSB = 2;
    localparam int VHI_LSB = IDX_LSB + SET_W;
    localparam int ENTRIES = WAYS * SETS;

    localparam int CTRL_SV = 8;
    localparam int CTRL_RC = 4;
    localparam int CTRL_TF = 2;
    localparam int CTRL_IX = 1;
    localparam int CTRL_AT = 0;

    localparam int LO_PPN = 10;
    localparam int LO_V   = 8;
    localparam int LO_PR  = 5;
    localparam int LO_SZ  = 4;
    localparam int LO_C   = 3;
    localparam int LO_D   = 2;
    localparam int LO_SH  = 1;

    typedef enum logic [1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic [VHI_W-1:0]  vpn_hi;
        logic [VLO_W-1:0]  vpn_lo;
        logic [ASID_W-1:0] asid;
    } tag_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       pr;
        logic             sz;
        logic             c;
        logic             d;
        logic             sh;
    } dat_t;

    typedef struct packed {
        logic             sv;
        logic [WAY_W-1:0] rc;
        logic             ix;
        logic             at;
    } ctrl_t;

    function automatic logic [SET_W-1:0] set_of(
        input logic [VPN_W-1:0]  vpn,
        input logic [ASID_W-1:0] asid,
        input logic              ix
    );
        logic [SET_W-1:0] base;
        base = vpn[IDX_LSB +: SET_W];
        return ix ? (base ^ asid[SET_W-1:0]) : base;
    endfunction

    function automatic tag_t tag_of(
        input logic [VPN_W-1:0]  vpn,
        input logic [ASID_W-1:0] asid,
        input logic              valid
    );
        tag_t t;
        t.valid  = valid;
        t.vpn_hi = vpn[VPN_W-1:VHI_LSB];
        t.vpn_lo = vpn[VLO_W-1:0];
        t.asid   = asid;
        return t;
    endfunction
endpackage

// File: rtl/tlb_regs.sv
module tlb_regs
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic [VPN_W-1:0]  hi_vpn,
    output logic [ASID_W-1:0] hi_asid,
    output dat_t              lo_dat,
    output logic              lo_v,
    output ctrl_t             ctrl,
    output logic              flush
);
    reg_sel_e wsel, rsel;
    logic     wr_hi, wr_lo, wr_ctrl;
    logic     bit9_unused;

    assign wsel        = reg_sel_e'(wr_sel);
    assign rsel        = reg_sel_e'(rd_sel);
    assign wr_hi       = wr_en && (wsel == SEL_HI);
    assign wr_lo       = wr_en && (wsel == SEL_LO);
    assign wr_ctrl     = wr_en && (wsel == SEL_CTRL);
    assign flush       = wr_ctrl && wr_data[CTRL_TF];
    assign bit9_unused = wr_data[9];

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_vpn  <= '0;
            hi_asid <= '0;
            lo_dat  <= '0;
            lo_v    <= 1'b0;
            ctrl    <= '0;
        end else begin
            if (wr_hi) begin
                hi_vpn  <= wr_data[31:32-VPN_W];
                hi_asid <= wr_data[ASID_W-1:0];
            end
            if (miss_valid) begin
                hi_vpn <= miss_vpn;
            end
            if (wr_lo) begin
                lo_dat.ppn <= wr_data[LO_PPN +: PPN_W];
                lo_dat.pr  <= wr_data[LO_PR +: 2];
                lo_dat.sz  <= wr_data[LO_SZ];
                lo_dat.c   <= wr_data[LO_C];
                lo_dat.d   <= wr_data[LO_D];
                lo_dat.sh  <= wr_data[LO_SH];
                lo_v       <= wr_data[LO_V];
            end
            if (wr_ctrl) begin
                ctrl.sv <= wr_data[CTRL_SV];
                ctrl.rc <= wr_data[CTRL_RC +: WAY_W];
                ctrl.ix <= wr_data[CTRL_IX];
                ctrl.at <= wr_data[CTRL_AT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rsel)
            SEL_HI: begin
                rd_data[31:32-VPN_W]  = hi_vpn;
                rd_data[ASID_W-1:0]   = hi_asid;
            end
            SEL_LO: begin
                rd_data[LO_PPN +: PPN_W] = lo_dat.ppn;
                rd_data[LO_V]            = lo_v;
                rd_data[LO_PR +: 2]      = lo_dat.pr;
                rd_data[LO_SZ]           = lo_dat.sz;
                rd_data[LO_C]            = lo_dat.c;
                rd_data[LO_D]            = lo_dat.d;
                rd_data[LO_SH]           = lo_dat.sh;
            end
            SEL_CTRL: begin
                rd_data[CTRL_SV]           = ctrl.sv;
                rd_data[CTRL_RC +: WAY_W]  = ctrl.rc;
                rd_data[CTRL_IX]           = ctrl.ix;
                rd_data[CTRL_AT]           = ctrl.at;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  logic                    we,
    input  logic [WAY_W-1:0]        we_way,
    input  logic [SET_W-1:0]        we_set,
    input  tag_t                    we_tag,
    input  dat_t                    we_dat,
    input  logic [SET_W-1:0]        rd_set,
    input  logic [WAY_W-1:0]        rd_way,
    output tag_t                    rd_tag,
    output dat_t                    rd_dat,
    input  logic [SET_W-1:0]        cmp_set,
    output tag_t [WAYS-1:0]         cmp_tags,
    output dat_t [WAYS-1:0]         cmp_dats,
    output logic [ENTRIES-1:0]      valid_vec
);
    tag_t [WAYS-1:0] rd_tags;
    dat_t [WAYS-1:0] rd_dats;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_t tag_q [SETS];
        dat_t dat_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++) begin
                    tag_q[s].valid <= 1'b0;
                end
            end else begin
                if (flush) begin
                    for (int s = 0; s < SETS; s++) begin
                        tag_q[s].valid <= 1'b0;
                    end
                end
                if (we && (we_way == WAY_W'(w))) begin
                    tag_q[we_set] <= we_tag;
                    dat_q[we_set] <= we_dat;
                end
            end
        end

        assign rd_tags[w]  = tag_q[rd_set];
        assign rd_dats[w]  = dat_q[rd_set];
        assign cmp_tags[w] = tag_q[cmp_set];
        assign cmp_dats[w] = dat_q[cmp_set];

        for (genvar s = 0; s < SETS; s++) begin : g_vld
            assign valid_vec[w*SETS + s] = tag_q[s].valid;
        end
    end

    assign rd_tag = rd_tags[rd_way];
    assign rd_dat = rd_dats[rd_way];
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tag_t [WAYS-1:0]   tags,
    input  dat_t [WAYS-1:0]   dats,
    input  tag_t              key,
    output logic              hit,
    output logic [WAY_W-1:0]  way,
    output logic [PPN_W-1:0]  ppn
);
    logic key_valid_unused;
    assign key_valid_unused = key.valid;

    always_comb begin
        hit = 1'b0;
        way = '0;
        ppn = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (tags[w].valid &&
                tags[w].vpn_hi == key.vpn_hi &&
                tags[w].vpn_lo == key.vpn_lo &&
                tags[w].asid   == key.asid) begin
                hit = 1'b1;
                way = WAY_W'(w);
                ppn = dats[w].ppn;
            end
        end
    end
endmodule

// File: rtl/tlb_loader.sv
module tlb_loader
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_wr_sel,
    input  logic [31:0] reg_wr_data,
    input  logic [1:0]  reg_rd_sel,
    output logic [31:0] reg_rd_data,
    input  logic        miss_valid,
    input  logic [21:0] miss_vpn,
    input  logic        load_strobe,
    input  logic [4:0]  rd_set,
    input  logic [1:0]  rd_way,
    output logic        rd_valid,
    output logic [14:0] rd_vpn_hi,
    output logic [1:0]  rd_vpn_lo,
    output logic [7:0]  rd_asid,
    output logic [18:0] rd_ppn,
    output logic [1:0]  rd_pr,
    output logic        rd_sz,
    output logic        rd_c,
    output logic        rd_d,
    output logic        rd_sh,
    input  logic [21:0] cmp_vpn,
    input  logic [7:0]  cmp_asid,
    output logic        cmp_hit,
    output logic [1:0]  cmp_way,
    output logic [18:0] cmp_ppn
);
    logic [VPN_W-1:0]  hi_vpn;
    logic [ASID_W-1:0] hi_asid;
    dat_t              lo_dat;
    logic              lo_v;
    ctrl_t             ctrl;
    logic              flush;
    logic [SET_W-1:0]  load_set;
    logic [WAY_W-1:0]  load_way;
    tag_t              load_tag;
    logic [SET_W-1:0]  cmp_set;
    tag_t              rd_tag;
    dat_t              rd_dat;
    tag_t [WAYS-1:0]   cmp_tags;
    dat_t [WAYS-1:0]   cmp_dats;
    logic [ENTRIES-1:0] valid_vec;
    logic              ctrl_unused;

    assign ctrl_unused = ctrl.sv ^ ctrl.at;

    tlb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_sel     (reg_wr_sel),
        .wr_data    (reg_wr_data),
        .rd_sel     (reg_rd_sel),
        .rd_data    (reg_rd_data),
        .miss_valid (miss_valid),
        .miss_vpn   (miss_vpn),
        .hi_vpn     (hi_vpn),
        .hi_asid    (hi_asid),
        .lo_dat     (lo_dat),
        .lo_v       (lo_v),
        .ctrl       (ctrl),
        .flush      (flush)
    );

    assign load_set = set_of(hi_vpn, hi_asid, ctrl.ix);
    assign load_way = ctrl.rc;
    assign load_tag = tag_of(hi_vpn, hi_asid, lo_v);
    assign cmp_set  = set_of(cmp_vpn, cmp_asid, ctrl.ix);

    tlb_array u_array (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .we        (load_strobe),
        .we_way    (load_way),
        .we_set    (load_set),
        .we_tag    (load_tag),
        .we_dat    (lo_dat),
        .rd_set    (rd_set),
        .rd_way    (rd_way),
        .rd_tag    (rd_tag),
        .rd_dat    (rd_dat),
        .cmp_set   (cmp_set),
        .cmp_tags  (cmp_tags),
        .cmp_dats  (cmp_dats),
        .valid_vec (valid_vec)
    );

    tlb_match u_match (
        .tags (cmp_tags),
        .dats (cmp_dats),
        .key  (tag_of(cmp_vpn, cmp_asid, 1'b1)),
        .hit  (cmp_hit),
        .way  (cmp_way),
        .ppn  (cmp_ppn)
    );

    assign rd_valid  = rd_tag.valid;
    assign rd_vpn_hi = rd_tag.vpn_hi;
    assign rd_vpn_lo = rd_tag.vpn_lo;
    assign rd_asid   = rd_tag.asid;
    assign rd_ppn    = rd_dat.ppn;
    assign rd_pr     = rd_dat.pr;
    assign rd_sz     = rd_dat.sz;
    assign rd_c      = rd_dat.c;
    assign rd_d      = rd_dat.d;
    assign rd_sh     = rd_dat.sh;
endmodule

// File: rtl/tlb_loader_chk.sv
module tlb_loader_chk
    import tlb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               miss_valid,
    input logic [VPN_W-1:0]   miss_vpn,
    input logic [VPN_W-1:0]   hi_vpn,
    input logic               load_strobe,
    input logic [SET_W-1:0]   load_set,
    input logic [WAY_W-1:0]   load_way,
    input logic               lo_v,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [1:0]         reg_rd_sel,
    input logic [31:0]        reg_rd_data
);
    logic [WAY_W+SET_W-1:0] load_bit;
    assign load_bit = {load_way, load_set};

    // R7
    miss_vpn_capture_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid |=> (hi_vpn == $past(miss_vpn)));

    // R6
    load_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (load_strobe && lo_v) |=> valid_vec[$past(load_bit)]);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && !load_strobe) |=> (valid_vec == '0));

    // R11
    idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_strobe && !flush) |=> $stable(valid_vec));

    // R2
    ctrl_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_sel == 2'd2) |-> ((reg_rd_data & ~32'h0000_0133) == 32'h0));
endmodule

bind tlb_loader tlb_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .miss_valid  (miss_valid),
    .miss_vpn    (miss_vpn),
    .hi_vpn      (hi_vpn),
    .load_strobe (load_strobe),
    .load_set    (load_set),
    .load_way    (load_way),
    .lo_v        (lo_v),
    .flush       (flush),
    .valid_vec   (valid_vec),
    .reg_rd_sel  (reg_rd_sel),
    .reg_rd_data (reg_rd_data)
);

// File: tb/sim_tlb_loader.sv
module sim_tlb_loader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = 2'd3;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = 2'd3;
    logic [31:0] reg_rd_data;
    logic        miss_valid = 1'b0;
    logic [21:0] miss_vpn = '0;
    logic        load_strobe = 1'b0;
    logic [4:0]  rd_set = '0;
    logic [1:0]  rd_way = '0;
    logic        rd_valid;
    logic [14:0] rd_vpn_hi;
    logic [1:0]  rd_vpn_lo;
    logic [7:0]  rd_asid;
    logic [18:0] rd_ppn;
    logic [1:0]  rd_pr;
    logic        rd_sz, rd_c, rd_d, rd_sh;
    logic [21:0] cmp_vpn = '0;
    logic [7:0]  cmp_asid = '0;
    logic        cmp_hit;
    logic [1:0]  cmp_way;
    logic [18:0] cmp_ppn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_loader u0 (.*);

    localparam logic [31:0] ADDR_A = 32'h8765_3C00;
    localparam logic [7:0]  ASID_A = 8'h2D;
    localparam logic [31:0] ADDR_D = 32'h0040_2000;
    localparam logic [31:0] PPN_A  = 32'h1234_5400;
    localparam logic [31:0] PPN_L1 = 32'h0000_1C00;
    localparam logic [31:0] PPN_L2 = 32'h0AAA_A800;
    localparam logic [31:0] PPN_L3 = 32'h1555_5400;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        step();
        reg_wr_en = 1'b0; reg_wr_sel = 2'd3;
    endtask

    task automatic load;
        load_strobe = 1'b1;
        step();
        load_strobe = 1'b0;
    endtask

    task automatic peek(input logic [4:0] s, input logic [1:0] w);
        rd_set = s; rd_way = w;
        #1;
    endtask

    task automatic rreg(input logic [1:0] sel, output logic [31:0] v);
        reg_rd_sel = sel;
        #1;
        v = reg_rd_data;
    endtask

    function automatic logic [31:0] hi_word(input logic [31:0] addr, input logic [7:0] asid);
        return {addr[31:10], 2'b00, asid};
    endfunction

    // low word with V=1, PR=3, SZ=0, C=1, D=0, SH=1
    function automatic logic [31:0] lo_word(input logic [31:0] ppn_addr);
        return {3'b000, ppn_addr[28:10], 1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    endfunction

    function automatic logic [4:0] exp_set(input logic [31:0] addr, input logic [7:0] asid, input logic ix);
        return ix ? (addr[16:12] ^ asid[4:0]) : addr[16:12];
    endfunction

    task automatic t_reset;
        logic [31:0] v;
        for (int s = 0; s < 3; s++) begin
            rreg(2'(s), v);
            chk("R1 register clear", v, 32'h0);
        end
        peek(5'd19, 2'd2);
        chk("R1 entry invalid", {31'b0, rd_valid}, 32'h0);
        cmp_vpn = ADDR_A[31:10]; cmp_asid = ASID_A; #1;
        chk("R1 no hit", {31'b0, cmp_hit}, 32'h0);
    endtask

    task automatic t_layout;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF); rreg(2'd0, v); chk("R2 high mask", v, 32'hFFFF_FCFF);
        wr(2'd1, 32'hFFFF_FFFF); rreg(2'd1, v); chk("R2 low mask", v, 32'h1FFF_FD7E);
        wr(2'd2, 32'hFFFF_FFFF); rreg(2'd2, v); chk("R2 control mask", v, 32'h0000_0133);
        wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    endtask

    task automatic t_load_ix0;
        logic [4:0] s;
        s = exp_set(ADDR_A, ASID_A, 1'b0);
        wr(2'd0, hi_word(ADDR_A, ASID_A));
        wr(2'd1, lo_word(PPN_A));
        wr(2'd2, 32'h0000_0020);
        load();
        peek(s, 2'd2);
        chk("R3 set from vpn bits", {31'b0, rd_valid}, 32'h1);
        chk("R6 vpn high", {17'b0, rd_vpn_hi}, {17'b0, ADDR_A[31:17]});
        chk("R6 vpn low", {30'b0, rd_vpn_lo}, {30'b0, ADDR_A[11:10]});
        chk("R6 asid", {24'b0, rd_asid}, {24'b0, ASID_A});
        chk("R6 ppn", {13'b0, rd_ppn}, {13'b0, PPN_A[28:10]});
        chk("R6 attrs", {26'b0, rd_pr, rd_sz, rd_c, rd_d, rd_sh}, 32'h0000_0035);
        peek(s, 2'd1);
        chk("R5 other way untouched", {31'b0, rd_valid}, 32'h0);
    endtask

    task automatic t_load_ix1;
        logic [4:0] s;
        s = exp_set(ADDR_A, ASID_A, 1'b1);
        wr(2'd2, 32'h0000_0012);
        load();
        peek(s, 2'd1);
        chk("R4 xor set valid", {31'b0, rd_valid}, 32'h1);
        chk("R4 xor set asid", {24'b0, rd_asid}, {24'b0, ASID_A});
        peek(exp_set(ADDR_A, ASID_A, 1'b0), 2'd1);
        chk("R4 plain set not written", {31'b0, rd_valid}, 32'h0);
    endtask

    task automatic t_compare;
        cmp_vpn = ADDR_A[31:10]; cmp_asid = ASID_A; #1;
        chk("R10 hit ix1", {31'b0, cmp_hit}, 32'h1);
        chk("R10 way ix1", {30'b0, cmp_way}, 32'h1);
        chk("R10 ppn ix1", {13'b0, cmp_ppn}, {13'b0, PPN_A[28:10]});
        cmp_vpn = ADDR_A[31:10] ^ 22'h1; #1;
        chk("R10 vpn low mismatch", {31'b0, cmp_hit}, 32'h0);
        wr(2'd2, 32'h0000_0020);
        cmp_vpn = ADDR_A[31:10]; cmp_asid = ASID_A; #1;
        chk("R10 hit ix0 way", {29'b0, cmp_hit, cmp_way}, 32'h6);
        cmp_asid = 8'h2E; #1;
        chk("R10 asid mismatch", {31'b0, cmp_hit}, 32'h0);
    endtask

    task automatic t_miss;
        logic [31:0] v;
        miss_valid = 1'b1; miss_vpn = 22'h0007D;
        step();
        miss_valid = 1'b0;
        rreg(2'd0, v);
        chk("R7 miss vpn keeps asid", v, {22'h0007D, 2'b00, ASID_A});
        reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = hi_word(ADDR_A, 8'h77);
        miss_valid = 1'b1; miss_vpn = 22'h3FFFC3;
        step();
        reg_wr_en = 1'b0; reg_wr_sel = 2'd3; miss_valid = 1'b0;
        rreg(2'd0, v);
        chk("R7 collision", v, {22'h3FFFC3, 2'b00, 8'h77});
    endtask

    task automatic t_same_cycle;
        logic [4:0] s;
        s = exp_set(ADDR_D, 8'h01, 1'b0);
        wr(2'd0, hi_word(ADDR_D, 8'h01));
        wr(2'd2, 32'h0000_0030);
        wr(2'd1, lo_word(PPN_L1));
        reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = lo_word(PPN_L2);
        load_strobe = 1'b1;
        step();
        reg_wr_en = 1'b0; reg_wr_sel = 2'd3; load_strobe = 1'b0;
        peek(s, 2'd3);
        chk("R8 old low value loaded", {13'b0, rd_ppn}, {13'b0, PPN_L1[28:10]});
        load();
        peek(s, 2'd3);
        chk("R8 new low value later", {13'b0, rd_ppn}, {13'b0, PPN_L2[28:10]});
    endtask

    task automatic t_isolation;
        logic [4:0] s;
        s = exp_set(ADDR_D, 8'h01, 1'b0);
        wr(2'd2, 32'h0000_0000);
        wr(2'd1, lo_word(PPN_L3));
        load();
        repeat (3) step();
        peek(s, 2'd0);
        chk("R5 way0 written", {13'b0, rd_ppn}, {13'b0, PPN_L3[28:10]});
        peek(s, 2'd3);
        chk("R11 way3 unchanged", {12'b0, rd_valid, rd_ppn}, {12'b0, 1'b1, PPN_L2[28:10]});
        peek(exp_set(ADDR_A, ASID_A, 1'b0), 2'd2);
        chk("R11 other set unchanged", {12'b0, rd_valid, rd_ppn}, {12'b0, 1'b1, PPN_A[28:10]});
    endtask

    task automatic t_flush;
        logic [31:0] v;
        logic [4:0]  sd;
        logic [4:0]  sa;
        sd = exp_set(ADDR_D, 8'h01, 1'b0);
        sa = exp_set(ADDR_A, ASID_A, 1'b0);
        wr(2'd2, 32'h0000_0004);
        rreg(2'd2, v);
        chk("R9 flush bit reads 0", v, 32'h0);
        peek(sd, 2'd3);
        chk("R9 flushed entry", {31'b0, rd_valid}, 32'h0);
        peek(sa, 2'd2);
        chk("R9 flushed entry 2", {31'b0, rd_valid}, 32'h0);
        wr(2'd2, 32'h0000_0010);
        load();
        wr(2'd0, hi_word(ADDR_A, ASID_A));
        reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 32'h0000_0024;
        load_strobe = 1'b1;
        step();
        reg_wr_en = 1'b0; reg_wr_sel = 2'd3; load_strobe = 1'b0;
        peek(sa, 2'd1);
        chk("R9 load with flush survives", {31'b0, rd_valid}, 32'h1);
        peek(sd, 2'd1);
        chk("R9 older entry cleared", {31'b0, rd_valid}, 32'h0);
        rreg(2'd2, v);
        chk("R8 control updated after load", v, 32'h0000_0020);
    endtask

    initial begin
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        t_reset();
        t_layout();
        t_load_ix0();
        t_load_ix1();
        t_compare();
        t_miss();
        t_same_cycle();
        t_isolation();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule